// File: doc/BRIEF.md
# Two-Master Quantum-Preemptive Bus Arbiter

This block decides which of two bus masters drives the address phase of one shared AHB-style bus. Master index 0 is the processor and master index 1 is the DMA/network master. Each master raises a request line. The current owner's address phase is described to the arbiter by three signals: a beat-accepted strobe, a last-beat flag and the HBURST-style burst code. The arbiter returns a registered one-hot grant and the index of the granted master.

A 32-bit configuration word controls arbitration. It selects priority or round-robin scheduling, a 2-bit priority code per master, a time slice ("quantum") of 2^n clocks or 2^n accepted beats, and a non-preemptive setting. It also chooses which fixed-length bursts the arbiter may split when a slice runs out, and which master is parked on the bus while nobody requests. An owner keeps the bus until one of three things happens at a permitted transfer boundary: it stops requesting, its slice expires while the other master waits, or a master of higher priority asks for the bus.

Top module: `duo_bus_arbiter`

## Requirements
- R1: While `rst_n` is low at a rising clock edge, `gnt_o` is 00 and `owner_o` is 0 after that edge. The round-robin pointer returns to master 0 and the slice counter is cleared.
- R2: With `cfg_i[0]`=1 (round-robin), two masters that both keep requesting take turns at every slice expiry. Each grant points the round-robin choice at the other master.
- R3: With `cfg_i[0]`=0 (priority), a master whose priority code is 10 beats a master with any other code. The codes are at `cfg_i[13:12]` for master 0 and `cfg_i[17:16]` for master 1, and 00, 01 and 11 all count as low. The high master takes the bus at the next permitted boundary and keeps it through slice expiries while it requests.
- R4: In priority mode, two requesting masters of equal priority are served round-robin exactly as in R2.
- R5: With `cfg_i[3]`=0 and `cfg_i[7:4]`=n<15, the owner yields after 2^n clocks of ownership, counting the clock it was granted in, if the other master requests at a permitted boundary. Otherwise the owner keeps the bus until such a boundary comes.
- R6: With `cfg_i[3]`=1, the slice counts only clocks in which `beat_i` is high.
- R7: With `cfg_i[7:4]`=15, no slice limit exists. A requesting owner loses the bus only to the priority rule of R3.
- R8: A permitted boundary is any of these: a cycle with no owner; a cycle with `beat_i` low; a beat with `last_i` high; a beat of burst code 000 (single) or 001 (undefined length); or a beat of a fixed burst that `cfg_i[2:1]` allows to split. Codes 01x are 4 beats, 10x are 8 beats and 11x are 16 beats. Setting 00 splits every fixed burst, 01 splits those longer than 4 beats, 10 splits those longer than 8, and 11 splits none.
- R9: With no request, `cfg_i[9:8]` picks the parked owner: 01 gives master 0, 10 gives master 1, and 00 or 11 leaves `gnt_o` at 00.
- R10: Bits 11:10, 15:14 and 31:18 of `cfg_i` have no effect on `gnt_o` or `owner_o`.
- R11: `gnt_o` never has more than one bit set, and `owner_o` is 1 exactly when `gnt_o` is 10.
- R12: The grant decision uses the inputs of one clock and appears on `gnt_o` after the next rising edge. At any other time the grant holds.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rst_n | input | 1 | Synchronous reset, active low |
| req_i | input | 2 | Request per master (bit 0 processor, bit 1 DMA) |
| beat_i | input | 1 | The owner has a beat accepted in this cycle |
| last_i | input | 1 | This beat is the final beat of the owner's burst |
| burst_i | input | 3 | Burst code of the owner's current transfer |
| cfg_i | input | CFG_W (32) | Arbitration configuration word |
| gnt_o | output | 2 | One-hot grant, registered |
| owner_o | output | 1 | Index of the granted master |

## Verification
The grant, and with it `owner_o`, is the only result. It is due exactly one rising edge after the cycle whose inputs decide it. The bench therefore sets every input after a falling edge, updates its own arithmetic model of the arbitration rules for that cycle, and compares both outputs at the following falling edge. Reset is checked the same way, one edge after `rst_n` is sampled low, both at start-up and in the middle of a run. Slice lengths, burst-split points and priority outcomes are sampled cycle by cycle over complete sweeps of the scheduling, unit, slice, split and priority fields.

// File: rtl/duo_arb_pkg.sv
// Shared types and constants for the two-master bus arbiter.
// Assumes exactly two masters; field positions of the configuration word
// are fixed here because the arbitration logic decodes them.
package duo_arb_pkg;

    localparam int NUM_M       = 2;
    localparam int IDX_W       = 1;
    localparam int PRIO_LSB    = 12;
    localparam int PRIO_STRIDE = 4;
    localparam logic [1:0] PRIO_HIGH = 2'b10;
    localparam int QSIZE_W     = 4;
    localparam logic [QSIZE_W-1:0] QSIZE_NONPRE = '1;

    typedef enum logic [1:0] {
        SPLIT_ALL   = 2'b00,
        SPLIT_GT4   = 2'b01,
        SPLIT_GT8   = 2'b10,
        SPLIT_NEVER = 2'b11
    } split_mode_e;

    typedef struct packed {
        logic                   rr_mode;
        split_mode_e            split;
        logic                   unit_beat;
        logic [QSIZE_W-1:0]     qsize;
        logic                   park_valid;
        logic [IDX_W-1:0]       park_idx;
        logic [NUM_M-1:0]       hi;
    } arb_cfg_t;

endpackage

// File: rtl/duo_arb_cfg_decode.sv
// Configuration decoder: turns the raw configuration word into the fields
// used by the arbiter. Reserved bits are never read. An illegal priority
// code counts as low; an illegal park code means "park nobody".
module duo_arb_cfg_decode
    import duo_arb_pkg::*;
#(
    parameter int CFG_W = 32
) (
    input  logic [CFG_W-1:0] cfg_i,
    output arb_cfg_t         cfg_o
);

    // Per-master priority decode, one slice per master.
    for (genvar m = 0; m < NUM_M; m++) begin : g_prio
        assign cfg_o.hi[m] = (cfg_i[PRIO_LSB + PRIO_STRIDE*m +: 2] == PRIO_HIGH);
    end

    // Scalar fields and the parked-master code.
    always_comb begin
        cfg_o.rr_mode    = cfg_i[0];
        cfg_o.split      = split_mode_e'(cfg_i[2:1]);
        cfg_o.unit_beat  = cfg_i[3];
        cfg_o.qsize      = cfg_i[4 +: QSIZE_W];
        cfg_o.park_valid = (cfg_i[9:8] == 2'b01) || (cfg_i[9:8] == 2'b10);
        cfg_o.park_idx   = cfg_i[9];
    end

endmodule

// File: rtl/duo_arb_boundary.sv
// Boundary detector: says whether the bus may change hands at the end of
// this cycle, given the owner's beat and the burst-split setting.
// Assumes burst_i follows the HBURST coding (000 single, 001 undefined,
// 01x four beats, 10x eight beats, 11x sixteen beats).
module duo_arb_boundary
    import duo_arb_pkg::*;
(
    input  logic        active_i,
    input  logic        beat_i,
    input  logic        last_i,
    input  logic [2:0]  burst_i,
    input  split_mode_e split_i,
    output logic        bound_o
);

    logic       fixed_len;
    logic [4:0] beats;
    logic       split_ok;

    // Burst length from the code.
    always_comb begin
        fixed_len = (burst_i[2:1] != 2'b00);
        case (burst_i[2:1])
            2'b01:   beats = 5'd4;
            2'b10:   beats = 5'd8;
            2'b11:   beats = 5'd16;
            default: beats = 5'd1;
        endcase
    end

    // May this fixed burst be cut under the current split setting.
    always_comb begin
        case (split_i)
            SPLIT_ALL: split_ok = 1'b1;
            SPLIT_GT4: split_ok = (beats > 5'd4);
            SPLIT_GT8: split_ok = (beats > 5'd8);
            default:   split_ok = 1'b0;
        endcase
    end

    // Combine into a single permission flag.
    always_comb begin
        bound_o = !active_i || !beat_i || last_i || !fixed_len || split_ok;
    end

endmodule

// File: rtl/duo_arb_quantum.sv
// Slice counter: counts quanta (clocks or accepted beats, chosen by the
// caller through inc_i) since the last grant decision and flags when the
// programmed power-of-two limit is reached. The all-ones size means no limit.
module duo_arb_quantum
    import duo_arb_pkg::*;
#(
    parameter int CNT_W = 16
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               clr_i,
    input  logic               inc_i,
    input  logic [QSIZE_W-1:0] size_i,
    output logic               expired_o
);

    localparam int LIM_W = CNT_W + 1;

    logic [CNT_W-1:0] cnt_q;
    logic [LIM_W-1:0] used;
    logic [LIM_W-1:0] limit;

    // Quanta used including the present one, and the limit.
    always_comb begin
        used      = {1'b0, cnt_q} + {{CNT_W{1'b0}}, inc_i};
        limit     = {{CNT_W{1'b0}}, 1'b1} << size_i;
        expired_o = (size_i != QSIZE_NONPRE) && (used >= limit);
    end

    // Saturating counter, cleared at each grant decision.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (clr_i) begin
            cnt_q <= '0;
        end else if (used[CNT_W]) begin
            cnt_q <= '1;
        end else begin
            cnt_q <= used[CNT_W-1:0];
        end
    end

    // R5
    fresh_quantum_chk: assert property (@(posedge clk) disable iff (!rst_n)
        clr_i && (size_i != '0) |=> (size_i != $past(size_i)) || !expired_o);

endmodule

// File: rtl/duo_arb_pick.sv
// Winner selection: given the requests, the priorities and the round-robin
// pointer, names the master that gets the bus if a decision is taken now.
// With no request the parked master (or nobody) is chosen.
module duo_arb_pick
    import duo_arb_pkg::*;
(
    input  logic [NUM_M-1:0] req_i,
    input  logic [NUM_M-1:0] hi_i,
    input  logic             rr_mode_i,
    input  logic [IDX_W-1:0] ptr_i,
    input  logic             park_valid_i,
    input  logic [IDX_W-1:0] park_idx_i,
    output logic             win_valid_o,
    output logic [IDX_W-1:0] win_idx_o
);

    // Resolve the winner from the request pattern.
    always_comb begin
        win_valid_o = 1'b1;
        win_idx_o   = ptr_i;
        if (req_i == '0) begin
            win_valid_o = park_valid_i;
            win_idx_o   = park_idx_i;
        end else if (!(&req_i)) begin
            win_idx_o = req_i[1];
        end else if (!rr_mode_i && (hi_i[0] != hi_i[1])) begin
            win_idx_o = hi_i[1];
        end
    end

endmodule

// File: rtl/duo_bus_arbiter.sv
// Two-master bus arbiter top. Holds the registered grant and the
// round-robin pointer, decides when re-arbitration is allowed and needed,
// and ties the decoder, boundary detector, slice counter and picker.
// Assumes the beat, last and burst inputs describe the current owner.
module duo_bus_arbiter
    import duo_arb_pkg::*;
#(
    parameter int CNT_W = 16,
    parameter int CFG_W = 32
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [NUM_M-1:0] req_i,
    input  logic             beat_i,
    input  logic             last_i,
    input  logic [2:0]       burst_i,
    input  logic [CFG_W-1:0] cfg_i,
    output logic [NUM_M-1:0] gnt_o,
    output logic             owner_o
);

    arb_cfg_t         cfg;
    logic [NUM_M-1:0] gnt_q;
    logic [IDX_W-1:0] ptr_q;
    logic [IDX_W-1:0] own_idx;
    logic [IDX_W-1:0] oth_idx;
    logic             active;
    logic             bound;
    logic             q_expired;
    logic             q_inc;
    logic             hand_back;
    logic             q_yield;
    logic             prio_take;
    logic             arb;
    logic             win_valid;
    logic [IDX_W-1:0] win_idx;
    logic [NUM_M-1:0] gnt_nxt;

    duo_arb_cfg_decode #(.CFG_W(CFG_W)) u_dec (
        .cfg_i (cfg_i),
        .cfg_o (cfg)
    );

    duo_arb_boundary u_bnd (
        .active_i (active),
        .beat_i   (beat_i),
        .last_i   (last_i),
        .burst_i  (burst_i),
        .split_i  (cfg.split),
        .bound_o  (bound)
    );

    duo_arb_quantum #(.CNT_W(CNT_W)) u_qnt (
        .clk       (clk),
        .rst_n     (rst_n),
        .clr_i     (arb),
        .inc_i     (q_inc),
        .size_i    (cfg.qsize),
        .expired_o (q_expired)
    );

    duo_arb_pick u_pick (
        .req_i        (req_i),
        .hi_i         (cfg.hi),
        .rr_mode_i    (cfg.rr_mode),
        .ptr_i        (ptr_q),
        .park_valid_i (cfg.park_valid),
        .park_idx_i   (cfg.park_idx),
        .win_valid_o  (win_valid),
        .win_idx_o    (win_idx)
    );

    // Current owner and the reasons to re-arbitrate.
    always_comb begin
        active    = |gnt_q;
        own_idx   = gnt_q[1];
        oth_idx   = ~own_idx;
        q_inc     = cfg.unit_beat ? beat_i : 1'b1;
        hand_back = !req_i[own_idx];
        q_yield   = q_expired && req_i[oth_idx];
        prio_take = !cfg.rr_mode && req_i[oth_idx] && cfg.hi[oth_idx] && !cfg.hi[own_idx];
        arb       = !active || (bound && (hand_back || q_yield || prio_take));
        gnt_nxt   = win_valid ? ({{(NUM_M-1){1'b0}}, 1'b1} << win_idx) : '0;
    end

    // Grant and round-robin pointer registers.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            gnt_q <= '0;
            ptr_q <= '0;
        end else if (arb) begin
            gnt_q <= gnt_nxt;
            if (win_valid) begin
                ptr_q <= ~win_idx;
            end
        end
    end

    assign gnt_o   = gnt_q;
    assign owner_o = gnt_q[1];

    // R11
    grant_onehot_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(gnt_o));

    // R8
    burst_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (|gnt_o) && beat_i && !last_i && (burst_i[2:1] != 2'b00) && (cfg_i[2:1] == 2'b11)
        |=> $stable(gnt_o));

    // R7
    nonpre_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (|gnt_o) && cfg_i[0] && (cfg_i[7:4] == 4'hF) && req_i[owner_o]
        |=> $stable(gnt_o));

    // R2
    rr_swap_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (|gnt_o) && (&req_i) && cfg_i[0] && q_expired && bound
        |=> (gnt_o != $past(gnt_o)));

endmodule

// File: tb/tb_duo_bus_arbiter.sv
module tb_duo_bus_arbiter;

    localparam int CLK_PERIOD = 10;
    localparam int WATCHDOG   = 150000;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [1:0]  req = 2'b00;
    logic        beat = 1'b0;
    logic        last = 1'b0;
    logic [2:0]  burst = 3'b000;
    logic [31:0] cfg = 32'h0;
    logic [1:0]  gnt_o;
    logic        owner_o;

    int vectors = 0;
    int miscompares = 0;

    logic [1:0]  m_gnt = 2'b00;
    logic        m_ptr = 1'b0;
    int          m_cnt = 0;
    logic [31:0] rnd = 32'h1234_5678;

    always #(CLK_PERIOD/2) clk = ~clk;

    duo_bus_arbiter dut (
        .clk     (clk),
        .rst_n   (rst_n),
        .req_i   (req),
        .beat_i  (beat),
        .last_i  (last),
        .burst_i (burst),
        .cfg_i   (cfg),
        .gnt_o   (gnt_o),
        .owner_o (owner_o)
    );

    function automatic logic [31:0] mk(input int rr, input int spl, input int unit,
                                       input int qs, input int park, input int p0, input int p1);
        logic [31:0] c;
        c = 32'h0;
        c[0]     = rr[0];
        c[2:1]   = spl[1:0];
        c[3]     = unit[0];
        c[7:4]   = qs[3:0];
        c[9:8]   = park[1:0];
        c[13:12] = p0[1:0];
        c[17:16] = p1[1:0];
        return c;
    endfunction

    task automatic next_rnd();
        rnd = rnd ^ (rnd << 13);
        rnd = rnd ^ (rnd >> 17);
        rnd = rnd ^ (rnd << 5);
    endtask

    // Arithmetic model of the requirements for one clock.
    task automatic model_step();
        bit act, o, x, hi0, hi1, hio, hix, expd, bnd, arb, vld, w;
        int inc, used, blen, thr, qs;
        act = (m_gnt != 2'b00);
        o   = m_gnt[1];
        x   = !o;
        hi0 = (cfg[13:12] == 2'b10);
        hi1 = (cfg[17:16] == 2'b10);
        hio = o ? hi1 : hi0;
        hix = o ? hi0 : hi1;
        qs  = int'(cfg[7:4]);
        inc = cfg[3] ? int'(beat) : 1;
        used = m_cnt + inc;
        expd = (qs != 15) && (used >= (1 << qs));
        blen = (burst >= 3'd2) ? (2 << int'(burst[2:1])) : 1;
        case (cfg[2:1])
            2'b00: thr = 0;
            2'b01: thr = 4;
            2'b10: thr = 8;
            default: thr = 1000;
        endcase
        bnd = !act || !beat || last || (burst < 3'd2) || (blen > thr);
        arb = !act || (bnd && (!req[o] || (expd && req[x]) ||
                               (!cfg[0] && req[x] && hix && !hio)));
        if (arb) begin
            vld = 1'b1;
            w   = m_ptr;
            if (req == 2'b00) begin
                vld = (cfg[9:8] == 2'b01) || (cfg[9:8] == 2'b10);
                w   = (cfg[9:8] == 2'b10);
            end else if (req == 2'b01) begin
                w = 1'b0;
            end else if (req == 2'b10) begin
                w = 1'b1;
            end else if (!cfg[0] && (hi0 != hi1)) begin
                w = hi1;
            end
            m_gnt = vld ? (w ? 2'b10 : 2'b01) : 2'b00;
            if (vld) m_ptr = !w;
            m_cnt = 0;
        end else begin
            m_cnt = used;
        end
    endtask

    task automatic check(input string tag);
        vectors++;
        if (gnt_o !== m_gnt || owner_o !== m_gnt[1]) begin
            miscompares++;
            $display("FAIL %s: gnt=%b owner=%b expected gnt=%b owner=%b",
                     tag, gnt_o, owner_o, m_gnt, m_gnt[1]);
        end
        vectors++;
        if ((gnt_o & (gnt_o - 2'd1)) != 2'b00 || owner_o !== gnt_o[1]) begin
            miscompares++;
            $display("FAIL R11: gnt=%b owner=%b expected at most one grant, owner=%b",
                     gnt_o, owner_o, gnt_o[1]);
        end
    endtask

    // Inputs are set; model the edge, then sample one edge later.
    task automatic cyc(input string tag);
        model_step();
        @(posedge clk);
        @(negedge clk);
        check(tag);
    endtask

    task automatic do_reset(input string tag);
        rst_n = 1'b0;
        @(posedge clk);
        @(negedge clk);
        m_gnt = 2'b00; m_ptr = 1'b0; m_cnt = 0;
        check(tag);
        vectors++;
        if (gnt_o !== 2'b00 || owner_o !== 1'b0) begin
            miscompares++;
            $display("FAIL %s: gnt=%b owner=%b expected gnt=00 owner=0", tag, gnt_o, owner_o);
        end
        rst_n = 1'b1;
    endtask

    // mode 0: both request, single beats; 1: random; 2: fixed bursts;
    // 3: no request; 4: both request, beat every other clock.
    task automatic run(input string tag, input logic [31:0] c, input int n,
                       input int mode, input logic [2:0] bt);
        int k;
        int blen;
        k = 0;
        blen = (bt >= 3'd2) ? (2 << int'(bt[2:1])) : 1;
        cfg = c;
        for (int i = 0; i < n; i++) begin
            next_rnd();
            case (mode)
                0: begin req = 2'b11; beat = 1'b1; burst = 3'd0; last = 1'b1; end
                1: begin req = rnd[1:0]; beat = rnd[2] | rnd[3]; burst = rnd[6:4];
                         last = rnd[7] & rnd[8]; end
                2: begin req = 2'b11; beat = 1'b1; burst = bt;
                         last = ((k % blen) == blen - 1); k++; end
                3: begin req = 2'b00; beat = rnd[2]; burst = rnd[6:4]; last = rnd[7]; end
                default: begin req = 2'b11; beat = i[0]; burst = 3'd0; last = i[0]; end
            endcase
            cyc(tag);
        end
    endtask

    initial begin
        repeat (WATCHDOG) @(posedge clk);
        miscompares++;
        $display("FAIL watchdog: run not finished, expected completion before %0d clocks", WATCHDOG);
        $display("  == %0d vectors applied, %0d miscompares ==", vectors, miscompares);
        $finish;
    end

    initial begin
        @(negedge clk);
        do_reset("R1");
        do_reset("R1");

        // R2: round-robin turns at slice expiry
        run("R2", mk(1, 3, 0, 0, 1, 1, 1), 10, 0, 3'd0);
        run("R2", mk(1, 3, 0, 1, 2, 2, 1), 12, 0, 3'd0);

        // R5: slice of 2^n clocks
        for (int q = 0; q < 5; q++) run("R5", mk(1, 3, 0, q, 1, 1, 1), 40, 0, 3'd0);

        // R6: slice counted in accepted beats
        for (int q = 0; q < 4; q++) run("R6", mk(1, 3, 1, q, 1, 1, 1), 40, 4, 3'd0);

        // R7: non-preemptive
        run("R7", mk(1, 0, 0, 15, 1, 1, 1), 30, 0, 3'd0);
        run("R7", mk(1, 0, 1, 15, 2, 1, 1), 60, 1, 3'd0);

        // R3: priority, with every pair of priority codes
        for (int a = 0; a < 4; a++)
            for (int b = 0; b < 4; b++) begin
                run("R3", mk(0, 0, 0, 0, 1, a, b), 8, 0, 3'd0);
                run("R3", mk(0, 0, 0, 1, 2, a, b), 30, 1, 3'd0);
            end

        // R4: equal priority served round-robin
        run("R4", mk(0, 3, 0, 0, 1, 2, 2), 12, 0, 3'd0);
        run("R4", mk(0, 3, 0, 1, 1, 1, 1), 12, 0, 3'd0);

        // R8: burst split settings against every fixed burst code
        for (int s = 0; s < 4; s++)
            for (int bt = 2; bt < 8; bt++)
                for (int q = 0; q < 2; q++)
                    run("R8", mk(1, s, 0, q, 1, 1, 1), 40, 2, 3'(bt));

        // R9: parked master
        for (int p = 0; p < 4; p++) begin
            run("R9", mk(1, 0, 0, 0, p, 1, 1), 6, 3, 3'd0);
            run("R9", mk(0, 0, 1, 2, p, 2, 1), 30, 1, 3'd0);
        end

        // R10: reserved bits set must change nothing
        for (int r = 0; r < 4; r++) begin
            next_rnd();
            run("R10", mk(r % 2, r, r / 2, r, 1 + r % 2, 2, 1) | (rnd & 32'hFFFC_CC00), 40, 1, 3'd0);
        end

        do_reset("R1");

        // R12: sweep of all scheduling fields under random traffic
        for (int rr = 0; rr < 2; rr++)
            for (int u = 0; u < 2; u++)
                for (int qi = 0; qi < 4; qi++)
                    for (int s = 0; s < 4; s++)
                        for (int a = 0; a < 4; a++)
                            for (int b = 0; b < 4; b++)
                                run("R12", mk(rr, s, u, (qi == 3) ? 15 : qi, 1 + (a % 2), a, b),
                                    24, 1, 3'd0);

        $display("  == %0d vectors applied, %0d miscompares ==", vectors, miscompares);
        $finish;
    end

endmodule